// File: doc/BRIEF.md
# Dual-Mode Flat Panel Timing Generator

This block turns a stream of pixel words into the signals a flat panel needs: a 16-bit data bus, a pixel clock, a line clock, a frame clock and a bias/enable pin, plus an output-enable that tells the pad ring to drive them. One configuration input picks the drive style. In passive (STN-style) mode the pixel clock pulses only for slots that carry real data, and the bias pin flips the panel's drive polarity every few frames. In active (TFT-style) mode the pixel clock runs without gaps, and the same bias pin marks the slots in which the bus carries valid pixels.

Each pixel slot lasts two clock cycles. In the first cycle the pixel clock is low and the data bus takes its new value. In the second cycle the pixel clock is high and the panel samples the bus. A line is a sync region, a back porch, an active run and a front porch, with each region's length in slots set by a configuration input. A frame is built from lines in the same way. Pixels arrive on a valid/ready handshake. If the source has no pixel for an active slot, that slot goes out empty. Configuration is taken only while the block is disabled, and enabling it always starts at the first slot of a frame. The upstream logic packs subpixels (for example three colour bits per pixel in passive colour mode) into the pixel word. This block only selects which lanes of that word reach the bus.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `ctl_en` is low, `pad_oe`, `pix_ready`, `pad_pclk`, `pad_lclk`, `pad_fclk`, `pad_bias` and every bit of `pad_data` are 0. They are 0 from the first clock edge that samples `ctl_en` low.
- R2: The clock edge that samples `ctl_en` high raises `pad_oe`. The cycle that follows is the first (low-clock) half of slot 0 of a new frame, so `pad_fclk` and `pad_lclk` are both high in it. The sync lengths must be at least 1.
- R3: A slot is two cycles. `pad_pclk` can be high only in the second cycle of a slot. `pad_data` changes only on the edge that begins a slot, so it is stable while `pad_pclk` is high.
- R4: With `cfg_active`=0 (passive), `pad_pclk` is high in the second cycle of a slot only if a pixel was accepted for that slot.
- R5: With `cfg_active`=1 (active), `pad_pclk` toggles on every cycle while enabled. `pad_bias` is high for exactly the slots that carry an accepted pixel.
- R6: In passive mode `pad_bias` starts at 0 on every enable and inverts at the start of each frame whose index is a multiple of `cfg_bias_frames`. A value of 0 acts as 1. At frame f, `pad_bias` = (f / period) mod 2.
- R7: `pad_lclk` is high during the first `cfg_hsync` slots of each line. A line runs sync, back porch, active run, front porch, in that order.
- R8: `pad_fclk` is high during every slot of the first `cfg_vsync` lines of each frame. Lines run sync, back porch, active, front porch, in that order. The vertical active count must be at least 1.
- R9: `pix_ready` is high only in the second cycle of the slot just before a slot that is active both horizontally and vertically. If `pix_valid` is high in that cycle, the pixel fills the next slot. Otherwise that slot carries no pixel and `pad_data` is 0.
- R10: Lane selection. In active mode all 16 bits are driven. In passive mode `cfg_panel`=0 (4-bit mono) drives bits 3:0, `cfg_panel`=4 (dual-panel colour) drives bits 15:0, and every other code (1 double-pixel mono, 2 dual-panel mono, 3 single-panel colour, 5 to 7) drives bits 7:0. Bits that are not driven are 0.
- R11: Changes to any `cfg_*` input while enabled have no effect. The block uses the values sampled on the enabling edge.
- R12: A line lasts hsync+hback+hact+hfront slots and a frame lasts vsync+vback+vact+vfront lines. Porch lengths of 0 are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Enable; high drives the panel |
| cfg_active | input | 1 | 1 selects active mode, 0 selects passive mode |
| cfg_panel | input | 3 | Passive panel type, selects the data lanes |
| cfg_hsync | input | HW | Line-clock length in slots |
| cfg_hback | input | HW | Horizontal back porch in slots |
| cfg_hact | input | HW | Pixels per line |
| cfg_hfront | input | HW | Horizontal front porch in slots |
| cfg_vsync | input | VW | Frame-clock length in lines |
| cfg_vback | input | VW | Vertical back porch in lines |
| cfg_vact | input | VW | Active lines per frame |
| cfg_vfront | input | VW | Vertical front porch in lines |
| cfg_bias_frames | input | BW | Passive bias inversion period in frames |
| pix_data | input | 16 | Pixel word |
| pix_valid | input | 1 | Pixel word present |
| pix_ready | output | 1 | Pixel accepted this cycle if valid |
| pad_data | output | 16 | Panel data bus |
| pad_pclk | output | 1 | Pixel clock |
| pad_lclk | output | 1 | Line clock / horizontal sync |
| pad_fclk | output | 1 | Frame clock / vertical sync |
| pad_bias | output | 1 | Passive: drive polarity; active: data enable |
| pad_oe | output | 1 | Pad output-enable |

## Verification
On every cycle the assertions check four things: the outputs are quiet while disabled, the bus holds steady while the pixel clock is high, the passive pixel clock never pulses without a handshake two cycles earlier, and the active clock never stops. They also check that a frame clock rises only together with a line clock and that the passive bias flips only where a frame begins. Some behaviour only the bench's scenarios can show, because it depends on the configured lengths and on which pixels were accepted. This covers the exact slot position of each sync region, the frame index at which the bias inverts, the lane masking for each panel code, the zero-porch layouts, and the fact that configuration written while running is ignored.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
package lcdt_pkg;

  localparam int DATA_W = 16;
  localparam int NIB_N  = DATA_W / 4;

  typedef enum logic [2:0] {
    PNL_MONO4      = 3'd0,
    PNL_MONO8      = 3'd1,
    PNL_DUAL_MONO  = 3'd2,
    PNL_COLOR      = 3'd3,
    PNL_DUAL_COLOR = 3'd4
  } panel_e;

  // Nibble-lane enables for the data bus, lowest nibble first.
  function automatic logic [NIB_N-1:0] lane_en(input logic act, input logic [2:0] pnl);
    logic [NIB_N-1:0] en;
    if (act || (pnl == PNL_DUAL_COLOR)) begin
      en = '1;
    end else if (pnl == PNL_MONO4) begin
      en = NIB_N'(1);
    end else begin
      en = NIB_N'(3);
    end
    return en;
  endfunction

endpackage

// File: rtl/lcdt_span_ctr.sv
`timescale 1ns/1ps
module lcdt_span_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         sel,
  input  logic [W-1:0] len_sync,
  input  logic [W-1:0] len_back,
  input  logic [W-1:0] len_act,
  input  logic [W-1:0] len_front,
  output logic         last,
  output logic         sync,
  output logic         act_sel
);

  localparam int TW = W + 2;

  logic [TW-1:0] pos_q, pos_d;
  logic [TW-1:0] act_lo, act_hi, total, pos_nxt, probe;

  assign act_lo  = TW'(len_sync) + TW'(len_back);
  assign act_hi  = act_lo + TW'(len_act);
  assign total   = act_hi + TW'(len_front);
  assign last    = (pos_q == (total - TW'(1)));
  assign pos_nxt = last ? '0 : (pos_q + TW'(1));
  assign sync    = (pos_q < TW'(len_sync));
  assign probe   = sel ? pos_nxt : pos_q;
  assign act_sel = (probe >= act_lo) && (probe < act_hi);

  always_comb begin
    pos_d = pos_q;
    if (clr) begin
      pos_d = '0;
    end else if (step) begin
      pos_d = pos_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/lcdt_bias_gen.sv
`timescale 1ns/1ps
module lcdt_bias_gen #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wrap,
  input  logic [BW-1:0] period,
  output logic          bias
);

  logic [BW-1:0] cnt_q, cnt_d, limit;
  logic          bias_q, bias_d;

  assign limit = (period == '0) ? '0 : (period - BW'(1));
  assign bias  = bias_q;

  always_comb begin
    cnt_d  = cnt_q;
    bias_d = bias_q;
    if (clr) begin
      cnt_d  = '0;
      bias_d = 1'b0;
    end else if (wrap) begin
      if (cnt_q >= limit) begin
        cnt_d  = '0;
        bias_d = ~bias_q;
      end else begin
        cnt_d = cnt_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bias_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bias_q <= bias_d;
    end
  end

endmodule

// File: rtl/lcdt_pix_lane.sv
`timescale 1ns/1ps
module lcdt_pix_lane #(
  parameter  int DW  = 16,
  localparam int NIB = DW / 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  input  logic           take,
  input  logic [NIB-1:0] nib_en,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  dout,
  output logic           vld
);

  logic vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr) begin
      vld_d = 1'b0;
    end else if (adv) begin
      vld_d = take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign vld = vld_q;

  for (genvar g = 0; g < NIB; g++) begin : g_nib
    logic [3:0] nib_q, nib_d;

    always_comb begin
      nib_d = nib_q;
      if (clr) begin
        nib_d = '0;
      end else if (adv) begin
        nib_d = (take && nib_en[g]) ? din[g*4 +: 4] : 4'h0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nib_q <= '0;
      end else begin
        nib_q <= nib_d;
      end
    end

    assign dout[g*4 +: 4] = nib_q;
  end

endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen #(
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_en,
  input  logic          cfg_active,
  input  logic [2:0]    cfg_panel,
  input  logic [HW-1:0] cfg_hsync,
  input  logic [HW-1:0] cfg_hback,
  input  logic [HW-1:0] cfg_hact,
  input  logic [HW-1:0] cfg_hfront,
  input  logic [VW-1:0] cfg_vsync,
  input  logic [VW-1:0] cfg_vback,
  input  logic [VW-1:0] cfg_vact,
  input  logic [VW-1:0] cfg_vfront,
  input  logic [BW-1:0] cfg_bias_frames,
  input  logic [15:0]   pix_data,
  input  logic          pix_valid,
  output logic          pix_ready,
  output logic [15:0]   pad_data,
  output logic          pad_pclk,
  output logic          pad_lclk,
  output logic          pad_fclk,
  output logic          pad_bias,
  output logic          pad_oe
);

  import lcdt_pkg::*;

  typedef struct packed {
    logic          act;
    logic [2:0]    pnl;
    logic [HW-1:0] hs, hb, ha, hf;
    logic [VW-1:0] vs, vb, va, vf;
    logic [BW-1:0] bper;
  } shadow_t;

  shadow_t shd_q, shd_d;
  logic    en_q, en_d;
  logic    ph_q, ph_d;
  logic    clr, adv, take, wrap;
  logic    h_last, h_sync, h_act_nxt;
  logic    v_last, v_sync, v_act_sel;
  logic    slot_vld, bias_pol;
  logic [DATA_W-1:0] data_q;

  // Configuration is taken only while disabled (including the enabling edge).
  always_comb begin
    shd_d = shd_q;
    if (!en_q) begin
      shd_d = '{act: cfg_active, pnl: cfg_panel,
                hs: cfg_hsync, hb: cfg_hback, ha: cfg_hact, hf: cfg_hfront,
                vs: cfg_vsync, vb: cfg_vback, va: cfg_vact, vf: cfg_vfront,
                bper: cfg_bias_frames};
    end
  end

  assign clr  = !ctl_en;
  assign en_d = ctl_en;
  assign ph_d = (ctl_en && en_q) ? ~ph_q : 1'b0;
  assign adv  = en_q && ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      en_q  <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      shd_q <= shd_d;
      en_q  <= en_d;
      ph_q  <= ph_d;
    end
  end

  lcdt_span_ctr #(.W(HW)) u_hspan (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(adv), .sel(1'b1),
    .len_sync(shd_q.hs), .len_back(shd_q.hb), .len_act(shd_q.ha), .len_front(shd_q.hf),
    .last(h_last), .sync(h_sync), .act_sel(h_act_nxt)
  );

  lcdt_span_ctr #(.W(VW)) u_vspan (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(adv && h_last), .sel(h_last),
    .len_sync(shd_q.vs), .len_back(shd_q.vb), .len_act(shd_q.va), .len_front(shd_q.vf),
    .last(v_last), .sync(v_sync), .act_sel(v_act_sel)
  );

  assign pix_ready = adv && h_act_nxt && v_act_sel;
  assign take      = pix_ready && pix_valid;
  assign wrap      = adv && h_last && v_last;

  lcdt_pix_lane #(.DW(DATA_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .take(take),
    .nib_en(lane_en(shd_q.act, shd_q.pnl)), .din(pix_data),
    .dout(data_q), .vld(slot_vld)
  );

  lcdt_bias_gen #(.BW(BW)) u_bias (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wrap(wrap),
    .period(shd_q.bper), .bias(bias_pol)
  );

  assign pad_oe   = en_q;
  assign pad_data = data_q;
  assign pad_pclk = en_q && ph_q && (shd_q.act || slot_vld);
  assign pad_lclk = en_q && h_sync;
  assign pad_fclk = en_q && v_sync;
  assign pad_bias = en_q && (shd_q.act ? slot_vld : bias_pol);

endmodule

// File: rtl/lcdt_chk.sv
`timescale 1ns/1ps
module lcdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_act,
  input logic        pix_ready,
  input logic        pix_valid,
  input logic [15:0] pad_data,
  input logic        pad_pclk,
  input logic        pad_lclk,
  input logic        pad_fclk,
  input logic        pad_bias,
  input logic        pad_oe
);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> (pad_data == 16'h0 && !pad_pclk && !pad_lclk && !pad_fclk && !pad_bias && !pix_ready)); // R1

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pad_pclk |-> $stable(pad_data)); // R3

  AST_PASSIVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pclk && !mode_act) |-> $past(pix_ready && pix_valid, 2)); // R4

  AST_ACTIVE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && $past(pad_oe) && mode_act) |-> (pad_pclk != $past(pad_pclk))); // R5

  AST_FRAME_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && pad_fclk && !$past(pad_fclk)) |-> pad_lclk); // R8

  AST_READY_BEFORE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |=> !pad_pclk); // R9

  AST_BIAS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && $past(pad_oe) && !mode_act && (pad_bias != $past(pad_bias)))
      |-> (pad_fclk && !$past(pad_fclk))); // R6

endmodule

bind lcd_timing_gen lcdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_act(shd_q.act),
  .pix_ready(pix_ready), .pix_valid(pix_valid), .pad_data(pad_data),
  .pad_pclk(pad_pclk), .pad_lclk(pad_lclk), .pad_fclk(pad_fclk),
  .pad_bias(pad_bias), .pad_oe(pad_oe)
);

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b0;
  logic        cfg_active = 1'b0;
  logic [2:0]  cfg_panel = '0;
  logic [9:0]  cfg_hsync = '0, cfg_hback = '0, cfg_hact = '0, cfg_hfront = '0;
  logic [9:0]  cfg_vsync = '0, cfg_vback = '0, cfg_vact = '0, cfg_vfront = '0;
  logic [7:0]  cfg_bias_frames = '0;
  logic [15:0] pix_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [15:0] pad_data;
  logic        pad_pclk, pad_lclk, pad_fclk, pad_bias, pad_oe;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .cfg_active(cfg_active),
    .cfg_panel(cfg_panel), .cfg_hsync(cfg_hsync), .cfg_hback(cfg_hback),
    .cfg_hact(cfg_hact), .cfg_hfront(cfg_hfront), .cfg_vsync(cfg_vsync),
    .cfg_vback(cfg_vback), .cfg_vact(cfg_vact), .cfg_vfront(cfg_vfront),
    .cfg_bias_frames(cfg_bias_frames), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pad_data(pad_data), .pad_pclk(pad_pclk),
    .pad_lclk(pad_lclk), .pad_fclk(pad_fclk), .pad_bias(pad_bias), .pad_oe(pad_oe)
  );

  // Model configuration captured at enable
  int m_hs, m_hb, m_ha, m_hf, m_vs, m_vb, m_va, m_vf, m_bp;
  bit m_act;
  logic [2:0] m_pnl;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_mask(input bit a, input logic [2:0] p);
    if (a || p == 3'd4) return 16'hFFFF;
    if (p == 3'd0) return 16'h000F;
    return 16'h00FF;
  endfunction

  function automatic int htot();
    return m_hs + m_hb + m_ha + m_hf;
  endfunction

  function automatic int vtot();
    return m_vs + m_vb + m_va + m_vf;
  endfunction

  function automatic bit slot_act(input int s);
    int hp, ln;
    hp = s % htot();
    ln = (s / htot()) % vtot();
    return (hp >= m_hs + m_hb) && (hp < m_hs + m_hb + m_ha) &&
           (ln >= m_vs + m_vb) && (ln < m_vs + m_vb + m_va);
  endfunction

  task automatic check_off(input string why);
    chk(pad_oe == 1'b0 && pix_ready == 1'b0, {"R1 oe/ready low ", why}, {pad_oe, pix_ready}, 0);
    chk(pad_data == 16'h0, {"R1 data zero ", why}, pad_data, 0);
    chk({pad_pclk, pad_lclk, pad_fclk, pad_bias} == 4'b0, {"R1 timing pins low ", why},
        {pad_pclk, pad_lclk, pad_fclk, pad_bias}, 0);
  endtask

  task automatic run_scn(input bit a, input logic [2:0] pnl,
                         input int hs, input int hb, input int ha, input int hf,
                         input int vs, input int vb, input int va, input int vf,
                         input int bp, input int vprob, input int nfr, input bit scramble);
    logic [15:0] e_data;
    bit e_vld;
    int ncyc, per;
    @(negedge clk);
    cfg_active = a; cfg_panel = pnl;
    cfg_hsync = 10'(hs); cfg_hback = 10'(hb); cfg_hact = 10'(ha); cfg_hfront = 10'(hf);
    cfg_vsync = 10'(vs); cfg_vback = 10'(vb); cfg_vact = 10'(va); cfg_vfront = 10'(vf);
    cfg_bias_frames = 8'(bp);
    m_act = a; m_pnl = pnl; m_hs = hs; m_hb = hb; m_ha = ha; m_hf = hf;
    m_vs = vs; m_vb = vb; m_va = va; m_vf = vf; m_bp = bp;
    per = (bp == 0) ? 1 : bp;
    ctl_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e_data = '0; e_vld = 1'b0;
    ncyc = 2 * htot() * vtot() * nfr;
    for (int k = 0; k < ncyc; k++) begin
      int s, ph, hp, ln, f;
      bit e_l, e_f, e_r, e_pc, e_b;
      s  = k / 2; ph = k % 2;
      hp = s % htot();
      ln = (s / htot()) % vtot();
      f  = s / (htot() * vtot());
      e_l = (hp < m_hs);
      e_f = (ln < m_vs);
      e_r = (ph == 1) && slot_act(s + 1);
      e_pc = (ph == 1) && (m_act || e_vld);
      e_b  = m_act ? e_vld : (((f / per) % 2) == 1);
      if (k == 0) chk(pad_oe && pad_fclk && pad_lclk, "R2 enable starts a frame",
                      {pad_oe, pad_fclk, pad_lclk}, 3'b111);
      chk(pad_oe == 1'b1, "R2 oe high while enabled", pad_oe, 1);
      chk(pad_lclk == e_l, "R7 R12 line clock position", pad_lclk, e_l);
      chk(pad_fclk == e_f, "R8 R11 frame clock position", pad_fclk, e_f);
      chk(pix_ready == e_r, "R9 ready before active slot", pix_ready, e_r);
      chk(pad_data == e_data, "R10 R3 data lanes", pad_data, e_data);
      if (m_act) begin
        chk(pad_pclk == e_pc, "R5 R3 free-running pclk", pad_pclk, e_pc);
        chk(pad_bias == e_b, "R5 bias as data enable", pad_bias, e_b);
      end else begin
        chk(pad_pclk == e_pc, "R4 R3 gated pclk", pad_pclk, e_pc);
        chk(pad_bias == e_b, "R6 bias polarity", pad_bias, e_b);
      end
      pix_data  = 16'($urandom);
      pix_valid = (($urandom % 100) < vprob);
      if (scramble) begin
        cfg_active = 1'($urandom); cfg_panel = 3'($urandom);
        cfg_hsync = 10'($urandom); cfg_hback = 10'($urandom);
        cfg_hact = 10'($urandom); cfg_hfront = 10'($urandom);
        cfg_vsync = 10'($urandom); cfg_vback = 10'($urandom);
        cfg_vact = 10'($urandom); cfg_vfront = 10'($urandom);
        cfg_bias_frames = 8'($urandom);
      end
      if (ph == 1) begin
        if (e_r && pix_valid) begin
          e_data = pix_data & exp_mask(m_act, m_pnl);
          e_vld  = 1'b1;
        end else begin
          e_data = '0;
          e_vld  = 1'b0;
        end
      end
      @(negedge clk);
    end
    ctl_en = 1'b0;
    pix_valid = 1'b0;
    @(negedge clk);
    check_off("after disable");
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check_off("in reset");
    rst_n = 1'b1;
    pix_valid = 1'b1;
    pix_data = 16'hBEEF;
    repeat (3) @(negedge clk);
    check_off("disabled with pixel offered");
    pix_valid = 1'b0;
    // Directed corner cases
    run_scn(1'b0, 3'd0, 1, 1, 4, 1, 1, 1, 2, 1, 2, 70, 6, 1'b0);   // mono4, bias every 2 frames
    run_scn(1'b0, 3'd0, 1, 1, 4, 1, 1, 1, 2, 1, 2, 70, 3, 1'b0);   // R6 restart at enable
    run_scn(1'b0, 3'd3, 1, 0, 3, 0, 1, 0, 2, 0, 0, 50, 4, 1'b0);   // zero porches, period 0
    run_scn(1'b0, 3'd4, 2, 1, 5, 1, 1, 1, 2, 1, 1, 100, 3, 1'b1);  // dual colour, R11 scramble
    run_scn(1'b1, 3'd0, 2, 2, 6, 3, 2, 1, 2, 1, 1, 80, 3, 1'b1);   // active, all lanes
    run_scn(1'b0, 3'd1, 1, 2, 3, 1, 2, 0, 1, 1, 3, 90, 4, 1'b0);   // double-pixel mono
    run_scn(1'b0, 3'd2, 3, 0, 2, 2, 1, 2, 1, 0, 1, 60, 3, 1'b0);   // dual mono
    run_scn(1'b1, 3'd4, 1, 0, 1, 0, 1, 0, 1, 0, 0, 0, 2, 1'b0);    // active, no pixels
    // Constrained random
    for (int i = 0; i < 10; i++) begin
      run_scn(1'($urandom), 3'($urandom % 6),
              1 + int'($urandom % 3), int'($urandom % 3), 1 + int'($urandom % 6), int'($urandom % 3),
              1 + int'($urandom % 2), int'($urandom % 2), 1 + int'($urandom % 3), int'($urandom % 2),
              int'($urandom % 4), int'($urandom % 101), 3, 1'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule